// File: doc/BRIEF.md
# Multi-Channel Register-Mapped PWM Generator

This block produces up to eight independent pulse-width-modulated outputs, each programmed through a small memory-mapped register interface. Each channel holds a configuration word, a 13-bit period and a 13-bit duty threshold. A per-channel prescaler turns the common clock into a tick stream. The source is either the clock itself or the clock divided by 1625, and a power-of-two stage then divides it by up to 128. Each tick advances the channel counter.

A global enable word at address zero turns individual channels on and off without disturbing the others. Software writes the period and threshold at any time. The running channel picks up new values only when its counter wraps, so a cycle in progress is never cut short or stretched. Register reads are combinational on the address, and writes take effect on the clock edge that samples the write strobe.

Top module: `pwm_ctrl_top`

## Requirements
- R1: After reset all registers read zero and every output is low.
- R2: The global enable word is at address 0x000, where bit n enables channel n. Channel banks start at 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 and 0x220 for channels 0 to 7. Within a bank, the configuration word is at +0x00, the period at +0x2C and the threshold at +0x30. Each value written reads back at its address.
- R3: In the configuration word, bits [2:0] hold the prescale exponent, bit 3 selects the divide-by-1625 source and bit 15 is the run mode. Period and threshold keep bits [12:0]. All other bits read zero.
- R4: A running channel with period P repeats every P+1 ticks. Its output is high while the counter, which starts at zero, is below the threshold.
- R5: With exponent d, one tick occurs every 2^d source pulses.
- R6: With bit 3 set, one source pulse occurs every 1625 clock cycles. With bit 3 clear, there is one source pulse every clock cycle.
- R7: A threshold of zero keeps the output low. A threshold above the period keeps it high.
- R8: Period and threshold writes take effect only at the next counter wrap.
- R9: Clearing a channel's enable bit drives its output low and restarts its counter and prescaler from zero, without affecting other channels.
- R10: A channel whose configuration bit 15 is clear stays low even when globally enabled.
- R11: Reads of unmapped addresses return zero, and writes to them change no register.
- R12: The output of a channel enabled with a nonzero threshold is high in the first cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (12) | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| pwm_out | output | NUM_CH (8) | One waveform per channel |

## Verification
A register write lands on the rising edge that samples the strobe, and reads are combinational. The bench therefore drives and samples bus values on falling edges: one falling edge after the strobe for read-back, and at once for a read. A channel output follows its registered counter, so the first sample after an enable write falls on the very next falling edge, at counter value zero. Duty and prescale results are counted over windows of whole periods so that the start phase cannot shift the count. The wrap-deferred update and the restart after disable are instead checked sample by sample against the counter value expected at each falling edge.

// File: rtl/pwm_pkg.sv
// Shared constants, configuration type and bank address map of the PWM block.
// Assumes at most eight channels and a 12-bit byte address space.
package pwm_pkg;
    localparam int MAX_CH  = 8;
    localparam int CNT_W   = 13;
    localparam int DIV_W   = 3;
    localparam int ALT_DIV = 1625;

    localparam int OFF_CFG = 'h000;
    localparam int OFF_PER = 'h02C;
    localparam int OFF_THR = 'h030;
    localparam int GLB_ADR = 'h000;

    typedef struct packed {
        logic             mode;
        logic             alt;
        logic [DIV_W-1:0] div;
    } ch_cfg_t;

    // Base byte address of a channel's register bank.
    function automatic int bank_base(input int ch);
        case (ch)
            0: return 'h010;
            1: return 'h050;
            2: return 'h090;
            3: return 'h0D0;
            4: return 'h110;
            5: return 'h150;
            6: return 'h190;
            default: return 'h220;
        endcase
    endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
// Per-channel prescaler: picks the clock or clock/ALT_DIV as source pulses,
// then emits one tick every 2^div source pulses. Holds at zero while idle.
module pwm_tick_gen
    import pwm_pkg::*;
#(
    parameter int ALT_N = ALT_DIV,
    parameter int EXP_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             alt,
    input  logic [EXP_W-1:0] div,
    output logic             tick
);
    localparam int SRC_W = $clog2(ALT_N);
    localparam int POW_W = (1 << EXP_W) - 1;

    logic [SRC_W-1:0] src_cnt;
    logic [POW_W-1:0] pow_cnt;
    logic [POW_W-1:0] mask;
    logic             src_pulse;

    // Derive the source pulse and the terminal count of the binary stage.
    always_comb begin
        src_pulse = !alt || (src_cnt == SRC_W'(ALT_N - 1));
        mask      = POW_W'((32'd1 << div) - 32'd1);
        tick      = run && src_pulse && (pow_cnt >= mask);
    end

    // Advance the fixed divider and the power-of-two divider.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            src_cnt <= '0;
            pow_cnt <= '0;
        end else begin
            if (alt) src_cnt <= src_pulse ? '0 : src_cnt + 1'b1;
            else     src_cnt <= '0;
            if (src_pulse) pow_cnt <= (pow_cnt >= mask) ? '0 : pow_cnt + 1'b1;
        end
    end

    // R6
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_cnt < SRC_W'(ALT_N));
    // R9
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (src_cnt == '0 && pow_cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: prescaler, wrap counter with shadowed period/threshold,
// and output compare. Shadow values load while idle and at each wrap.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  ch_cfg_t      cfg,
    input  logic [W-1:0] per_sh,
    input  logic [W-1:0] thr_sh,
    output logic         pwm
);
    logic [W-1:0] cnt;
    logic [W-1:0] per_act;
    logic [W-1:0] thr_act;
    logic         tick;
    logic         wrap;

    pwm_tick_gen #(.ALT_N(ALT_DIV), .EXP_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .alt  (cfg.alt),
        .div  (cfg.div),
        .tick (tick)
    );

    // Flag the tick on which the counter returns to zero.
    always_comb wrap = tick && (cnt >= per_act);

    // Count ticks; reload the active period and threshold at wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            per_act <= '0;
            thr_act <= '0;
        end else if (!run || wrap) begin
            cnt     <= '0;
            per_act <= per_sh;
            thr_act <= thr_sh;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare the counter with the active threshold.
    always_comb pwm = run && (cnt < thr_act);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= per_act);
    // R8
    hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(per_act) && $stable(thr_act)));
    // R7
    zero_thr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && thr_act == '0) |-> !pwm);
    // R7
    big_thr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && thr_act > per_act) |-> pwm);
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/pwm_regs.sv
// Register file: global enable word plus one configuration, period and
// threshold register per channel. Reads are combinational; unmapped
// addresses read zero and ignore writes.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = MAX_CH,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] glb_en,
    output ch_cfg_t           cfg    [NUM_CH],
    output logic [CNT_W-1:0]  per    [NUM_CH],
    output logic [CNT_W-1:0]  thr    [NUM_CH]
);
    logic              hit_glb;
    logic [NUM_CH-1:0] hit_cfg, hit_per, hit_thr;
    logic              hit_any;

    // Decode the global word address.
    always_comb hit_glb = (addr == ADDR_W'(GLB_ADR));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        assign hit_cfg[c] = (addr == ADDR_W'(bank_base(c) + OFF_CFG));
        assign hit_per[c] = (addr == ADDR_W'(bank_base(c) + OFF_PER));
        assign hit_thr[c] = (addr == ADDR_W'(bank_base(c) + OFF_THR));

        // Capture writes to this channel's bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[c] <= '0;
                per[c] <= '0;
                thr[c] <= '0;
            end else if (wr_en) begin
                if (hit_cfg[c]) begin
                    cfg[c].mode <= wdata[15];
                    cfg[c].alt  <= wdata[3];
                    cfg[c].div  <= wdata[DIV_W-1:0];
                end
                if (hit_per[c]) per[c] <= wdata[CNT_W-1:0];
                if (hit_thr[c]) thr[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    // Collect any address hit.
    always_comb hit_any = hit_glb || (|hit_cfg) || (|hit_per) || (|hit_thr);

    // Capture writes to the global enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)                  glb_en <= '0;
        else if (wr_en && hit_glb)   glb_en <= wdata[NUM_CH-1:0];
    end

    // Multiplex the addressed register onto the read bus.
    always_comb begin
        rdata = '0;
        if (hit_glb) rdata[NUM_CH-1:0] = glb_en;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_cfg[c]) begin
                rdata[15]         = cfg[c].mode;
                rdata[3]          = cfg[c].alt;
                rdata[DIV_W-1:0]  = cfg[c].div;
            end
            if (hit_per[c]) rdata[CNT_W-1:0] = per[c];
            if (hit_thr[c]) rdata[CNT_W-1:0] = thr[c];
        end
    end

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> rdata == '0);
    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any) |=> $stable(glb_en));
endmodule

// File: rtl/pwm_ctrl_top.sv
// Top of the PWM block: register file plus NUM_CH channels. A channel runs
// when both its global enable bit and its mode bit are set. NUM_CH <= 8.
module pwm_ctrl_top
    import pwm_pkg::*;
#(
    parameter int NUM_CH = MAX_CH,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0] glb_en;
    ch_cfg_t           cfg [NUM_CH];
    logic [CNT_W-1:0]  per [NUM_CH];
    logic [CNT_W-1:0]  thr [NUM_CH];
    logic [NUM_CH-1:0] run;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .glb_en(glb_en),
        .cfg   (cfg),
        .per   (per),
        .thr   (thr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign run[c] = glb_en[c] && cfg[c].mode;

        pwm_channel #(.W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run[c]),
            .cfg   (cfg[c]),
            .per_sh(per[c]),
            .thr_sh(thr[c]),
            .pwm   (pwm_out[c])
        );
    end

    // R10
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((glb_en & ~run) & pwm_out) == '0);
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en == '0) |-> (pwm_out == '0));
endmodule

// File: tb/sim_pwm_ctrl_top.sv
// Directed bench for pwm_ctrl_top: one task per scenario, each checking its
// own results on falling edges.
module sim_pwm_ctrl_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [NCH-1:0] pwm;

    int checks = 0;
    int errors = 0;

    pwm_ctrl_top #(.NUM_CH(NCH), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int base(input int ch);
        int b [8] = '{'h010, 'h050, 'h090, 'h0D0, 'h110, 'h150, 'h190, 'h220};
        return b[ch];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one register; returns on the falling edge after the write edge.
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'(a); wdata = 32'(d);
        @(negedge clk);
        wr_en = 1'b0; addr = 12'h004;
    endtask

    task automatic rd(input int a, output int d);
        addr = 12'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic setup(input int ch, input int c, input int p, input int t);
        wr(base(ch) + 'h00, c);
        wr(base(ch) + 'h2C, p);
        wr(base(ch) + 'h30, t);
    endtask

    // Count high samples of one channel over n falling edges starting now.
    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm[ch]) hi++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int d;
        rd('h000, d);             chk("R1 global", d, 0);
        rd(base(0) + 'h2C, d);    chk("R1 period", d, 0);
        chk("R1 outputs", int'(pwm), 0);
    endtask

    task automatic t_map;
        int d;
        wr(base(7) + 'h00, 32'hFFFF_FFFF);
        rd(base(7) + 'h00, d);    chk("R3 cfg fields", d, 'h800F);
        wr(base(7) + 'h2C, 'hFFFF);
        rd(base(7) + 'h2C, d);    chk("R3 period width", d, 'h1FFF);
        wr(base(7) + 'h30, 'h1234);
        rd(base(7) + 'h30, d);    chk("R2 threshold", d, 'h1234);
        wr(base(3) + 'h00, 'h8005);
        rd(base(3) + 'h00, d);    chk("R2 bank3 cfg", d, 'h8005);
        rd(base(2) + 'h00, d);    chk("R2 bank2 untouched", d, 0);
        wr('h000, 32'hFFFF_FFFF);
        rd('h000, d);             chk("R2 global", d, 'hFF);
        wr('h000, 0);
        wr(base(7) + 'h00, 0);
        wr(base(3) + 'h00, 0);
    endtask

    task automatic t_duty;
        int hi;
        setup(0, 'h8000, 9, 3);
        wr('h000, 1);
        chk("R12 first cycle high", int'(pwm[0]), 1);
        count_high(0, 100, hi);   chk("R4 duty 3/10", hi, 30);
        wr('h000, 0);
    endtask

    task automatic t_prescale;
        int hi;
        setup(1, 'h8002, 4, 2);
        wr('h000, 2);
        count_high(1, 200, hi);   chk("R5 div4 duty", hi, 80);
        wr('h000, 0);
    endtask

    task automatic t_alt;
        int hi;
        setup(2, 'h8008, 1, 1);
        wr('h000, 4);
        count_high(2, 6500, hi);  chk("R6 div1625 duty", hi, 3250);
        wr('h000, 0);
    endtask

    task automatic t_limits;
        int hi;
        setup(0, 'h8000, 9, 0);
        wr('h000, 1);
        count_high(0, 30, hi);    chk("R7 zero threshold", hi, 0);
        wr('h000, 0);
        setup(0, 'h8000, 9, 12);
        wr('h000, 1);
        count_high(0, 30, hi);    chk("R7 big threshold", hi, 30);
        wr('h000, 0);
    endtask

    task automatic t_shadow;
        int bad = 0;
        setup(0, 'h8000, 9, 5);
        wr('h000, 1);
        wr(base(0) + 'h30, 2);    // lands between k=1 and k=2
        for (int k = 2; k < 20; k++) begin
            int e = (k < 10) ? int'(k < 5) : int'((k - 10) < 2);
            if (int'(pwm[0]) != e) bad++;
            @(negedge clk);
        end
        chk("R8 deferred threshold", bad, 0);
        wr('h000, 0);
    endtask

    task automatic t_disable;
        int hi, bad;
        setup(0, 'h8000, 9, 3);
        setup(1, 'h8000, 9, 3);
        wr('h000, 3);
        repeat (5) @(negedge clk);
        wr('h000, 2);
        chk("R9 disabled low", int'(pwm[0]), 0);
        count_high(1, 20, hi);    chk("R9 neighbour runs", hi, 6);
        wr('h000, 3);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (int'(pwm[0]) != int'(k < 3)) bad++;
            @(negedge clk);
        end
        chk("R9 restart from zero", bad, 0);
        wr('h000, 0);
    endtask

    task automatic t_mode;
        int hi;
        setup(0, 'h0000, 9, 3);
        wr('h000, 1);
        count_high(0, 20, hi);    chk("R10 mode clear low", hi, 0);
        wr('h000, 0);
    endtask

    task automatic t_unmapped;
        int d;
        wr('h004, 32'hFFFF_FFFF);
        rd('h000, d);             chk("R11 global unchanged", d, 0);
        rd('h004, d);             chk("R11 read zero", d, 0);
        wr(base(0) + 'h04, 'h0FFF);
        rd(base(0) + 'h2C, d);    chk("R11 period unchanged", d, 9);
        rd(base(0) + 'h30, d);    chk("R11 threshold unchanged", d, 3);
        chk("R11 outputs low", int'(pwm), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_duty();
        t_prescale();
        t_alt();
        t_limits();
        t_shadow();
        t_disable();
        t_mode();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule